// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block is the software-visible register file of an I/O address translation unit. A processor reaches it through a simple 32-bit word bus: a byte address, separate read and write strobes, write data in and read data out. Each register keeps only the bits that have meaning for it and forces some fixed bits to constant values. The control register also selects the size of the device virtual address window. The bank turns that size into a window-start mask, which the translation logic uses to strip the window base from incoming device addresses.

The translation engine reports a fault by strobing a status word and an offending address into the bank. The bank then raises a fault interrupt. The interrupt stays high until software reads or writes either fault register. Read data is combinational from the address. Address bits 1:0 are ignored because only whole-word accesses exist.

Top module: `xlat_csr_bank`

## Requirements
- R1: The control register at offset 0x0000 keeps only the written bits under mask 0x0000001D. Its bits 31:24 always read as the VERSION parameter, and all other bits read as zero.
- R2: A write to the control register loads `win_mask` with ones in bits 31 down to 24+n and zeros below, where n is written bit field 4:2 (n=0 gives 0xFF000000, n=7 gives 0x80000000). The new mask is visible from the clock edge that takes the write, and it changes on no other event.
- R3: The table-base register at offset 0x0004 stores the written word ANDed with 0x07FFFC00.
- R4: The two flush registers at offsets 0x0014 and 0x0018 store all 32 written bits.
- R5: The fault status register at 0x1000 stores the written word ANDed with 0xFF0FFFFF, with bit 23 always read as 1. The fault address register at 0x1004 stores all 32 written bits.
- R6: The four slot configuration registers at 0x1010, 0x1014, 0x1018 and 0x101C each store the written word ANDed with 0x00010003, independently of one another.
- R7: The arbiter enable register at 0x2000 stores the written word ANDed with 0x001F0000, with bit 3 always read as 1.
- R8: After reset, control reads VERSION in bits 31:24 and zero elsewhere, arbiter enable reads 0x00000008, fault status reads 0x00800000, and every other register reads 0. `win_mask` is 0 and `fault_irq` is low.
- R9: A cycle with `flt_strobe` high loads fault status (under the R5 mask and forced bit) from `flt_status` and fault address from `flt_addr`. It sets `fault_irq` from the next edge. When it coincides with a bus write to a fault register, the capture values win.
- R10: A read or write of either fault register clears `fault_irq` at the next edge, unless `flt_strobe` is high in the same cycle. An access to any other register leaves `fault_irq` unchanged.
- R11: Reads of unmapped word offsets return 0, and writes to them change no register. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (14) | Byte address of the access |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe (used for interrupt clearing) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| flt_strobe | input | 1 | Fault capture strobe from the translation engine |
| flt_status | input | 32 | Fault status word to capture |
| flt_addr | input | 32 | Faulting address to capture |
| win_mask | output | 32 | Window-start mask derived from the control range field |
| fault_irq | output | 1 | Fault interrupt, level |

## Verification
Stored register state is visible on `bus_rdata` in the same cycle its address is presented. A bad mask or a lost forced bit therefore shows at the first read that follows the write. Any wrong window decode appears on `win_mask` one edge after the control write. A stuck or wrongly ordered interrupt shows on `fault_irq` at the edge after the capture strobe or the fault register access. Capture priority shows in the fault address read that follows a collision.

// File: rtl/xlat_csr_pkg.sv
package xlat_csr_pkg;

    localparam int DATA_W     = 32;
    localparam int SLOT_IDX_W = 4;

    localparam logic [31:0] OFS_CTRL   = 32'h0000_0000;
    localparam logic [31:0] OFS_BASE   = 32'h0000_0004;
    localparam logic [31:0] OFS_TLBF   = 32'h0000_0014;
    localparam logic [31:0] OFS_PGF    = 32'h0000_0018;
    localparam logic [31:0] OFS_FSTAT  = 32'h0000_1000;
    localparam logic [31:0] OFS_FADDR  = 32'h0000_1004;
    localparam logic [31:0] OFS_SLOT0  = 32'h0000_1010;
    localparam logic [31:0] OFS_ARB    = 32'h0000_2000;

    localparam logic [DATA_W-1:0] KEEP_CTRL  = 32'h0000_001D;
    localparam logic [DATA_W-1:0] KEEP_BASE  = 32'h07FF_FC00;
    localparam logic [DATA_W-1:0] KEEP_FSTAT = 32'hFF0F_FFFF;
    localparam logic [DATA_W-1:0] SET_FSTAT  = 32'h0080_0000;
    localparam logic [DATA_W-1:0] KEEP_SLOT  = 32'h0001_0003;
    localparam logic [DATA_W-1:0] KEEP_ARB   = 32'h001F_0000;
    localparam logic [DATA_W-1:0] SET_ARB    = 32'h0000_0008;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_BASE,
        SEL_TLBF,
        SEL_PGF,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_SLOT,
        SEL_ARB
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e                sel;
        logic [SLOT_IDX_W-1:0]   slot;
    } csr_hit_t;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] addr;
    } fault_rec_t;

    function automatic logic [DATA_W-1:0] window_mask(input logic [2:0] range_sel);
        logic [5:0] sh;
        sh = 6'd24 + {3'b000, range_sel};
        return {DATA_W{1'b1}} << sh;
    endfunction

    function automatic logic [DATA_W-1:0] fold_fstat(input logic [DATA_W-1:0] w);
        return (w & KEEP_FSTAT) | SET_FSTAT;
    endfunction

endpackage

// File: rtl/xlat_csr_decode.sv
module xlat_csr_decode
    import xlat_csr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int SLOTS  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_hit_t          hit
);
    logic [ADDR_W-1:0] aligned;
    logic              addr_lsb_unused;

    assign aligned         = {addr[ADDR_W-1:2], 2'b00};
    assign addr_lsb_unused = ^addr[1:0];

    always_comb begin
        hit.sel  = SEL_NONE;
        hit.slot = '0;
        if (aligned == ADDR_W'(OFS_CTRL))  hit.sel = SEL_CTRL;
        if (aligned == ADDR_W'(OFS_BASE))  hit.sel = SEL_BASE;
        if (aligned == ADDR_W'(OFS_TLBF))  hit.sel = SEL_TLBF;
        if (aligned == ADDR_W'(OFS_PGF))   hit.sel = SEL_PGF;
        if (aligned == ADDR_W'(OFS_FSTAT)) hit.sel = SEL_FSTAT;
        if (aligned == ADDR_W'(OFS_FADDR)) hit.sel = SEL_FADDR;
        if (aligned == ADDR_W'(OFS_ARB))   hit.sel = SEL_ARB;
        for (int i = 0; i < SLOTS; i++) begin
            if (aligned == ADDR_W'(OFS_SLOT0 + 32'(4 * i))) begin
                hit.sel  = SEL_SLOT;
                hit.slot = SLOT_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlat_window_decode.sv
module xlat_window_decode
    import xlat_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [2:0]        range_sel,
    output logic [DATA_W-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (load) begin
            mask <= window_mask(range_sel);
        end
    end
endmodule

// File: rtl/xlat_fault_irq.sv
module xlat_fault_irq (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic touch,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (capture) begin
            irq <= 1'b1;
        end else if (touch) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/xlat_csr_bank.sv
module xlat_csr_bank
    import xlat_csr_pkg::*;
#(
    parameter int          ADDR_W  = 14,
    parameter int          SLOTS   = 4,
    parameter logic [7:0]  VERSION = 8'hA3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic              bus_ren,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              flt_strobe,
    input  logic [31:0]       flt_status,
    input  logic [31:0]       flt_addr,
    output logic [31:0]       win_mask,
    output logic              fault_irq
);
    localparam logic [DATA_W-1:0] VER_WORD = {VERSION, 24'h00_0000};

    csr_hit_t          hit;
    fault_rec_t        cap;
    logic [DATA_W-1:0] ctrl_q, base_q, tlbf_q, pgf_q, fstat_q, faddr_q, arb_q;
    logic [DATA_W-1:0] slot_q [SLOTS];
    logic              fault_touch;
    logic              ctrl_load;

    assign cap.status = flt_status;
    assign cap.addr   = flt_addr;

    xlat_csr_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign ctrl_load   = bus_wen && (hit.sel == SEL_CTRL);
    assign fault_touch = (bus_wen || bus_ren) &&
                         ((hit.sel == SEL_FSTAT) || (hit.sel == SEL_FADDR));

    xlat_window_decode u_win (
        .clk       (clk),
        .rst       (rst),
        .load      (ctrl_load),
        .range_sel (bus_wdata[4:2]),
        .mask      (win_mask)
    );

    xlat_fault_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .capture (flt_strobe),
        .touch   (fault_touch),
        .irq     (fault_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            tlbf_q <= '0;
            pgf_q  <= '0;
            arb_q  <= SET_ARB;
        end else if (bus_wen) begin
            case (hit.sel)
                SEL_CTRL: ctrl_q <= bus_wdata & KEEP_CTRL;
                SEL_BASE: base_q <= bus_wdata & KEEP_BASE;
                SEL_TLBF: tlbf_q <= bus_wdata;
                SEL_PGF:  pgf_q  <= bus_wdata;
                SEL_ARB:  arb_q  <= (bus_wdata & KEEP_ARB) | SET_ARB;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fstat_q <= SET_FSTAT;
            faddr_q <= '0;
        end else if (flt_strobe) begin
            fstat_q <= fold_fstat(cap.status);
            faddr_q <= cap.addr;
        end else if (bus_wen) begin
            if (hit.sel == SEL_FSTAT) fstat_q <= fold_fstat(bus_wdata);
            if (hit.sel == SEL_FADDR) faddr_q <= bus_wdata;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (bus_wen && hit.sel == SEL_SLOT &&
                         hit.slot == SLOT_IDX_W'(g)) begin
                slot_q[g] <= bus_wdata & KEEP_SLOT;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (hit.sel)
            SEL_CTRL:  bus_rdata = ctrl_q | VER_WORD;
            SEL_BASE:  bus_rdata = base_q;
            SEL_TLBF:  bus_rdata = tlbf_q;
            SEL_PGF:   bus_rdata = pgf_q;
            SEL_FSTAT: bus_rdata = fstat_q;
            SEL_FADDR: bus_rdata = faddr_q;
            SEL_ARB:   bus_rdata = arb_q;
            SEL_SLOT: begin
                for (int i = 0; i < SLOTS; i++) begin
                    if (hit.slot == SLOT_IDX_W'(i)) bus_rdata = slot_q[i];
                end
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlat_csr_bank_chk.sv
module xlat_csr_bank_chk #(
    parameter int         ADDR_W  = 14,
    parameter logic [7:0] VERSION = 8'hA3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic              bus_ren,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              flt_strobe,
    input logic              fault_irq,
    input logic [31:0]       win_mask
);
    logic [ADDR_W-1:0] aligned;
    logic              touch;
    logic              ctrl_wr;
    logic              chk_unused;

    assign aligned    = {bus_addr[ADDR_W-1:2], 2'b00};
    assign touch      = (bus_wen || bus_ren) &&
                        (aligned == ADDR_W'(32'h1000) || aligned == ADDR_W'(32'h1004));
    assign ctrl_wr    = bus_wen && (aligned == '0);
    assign chk_unused = ^{bus_addr[1:0], bus_wdata[31:5], bus_wdata[1:0]};

    // R1
    a_r1_version_byte: assert property (@(posedge clk) disable iff (rst)
        (aligned == '0) |-> (bus_rdata[31:24] == VERSION));

    // R2
    a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (win_mask == (32'hFFFF_FFFF << (6'd24 + {3'b000, $past(bus_wdata[4:2])}))));

    // R2
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(win_mask));

    // R5
    a_r5_resv_bit: assert property (@(posedge clk) disable iff (rst)
        (aligned == ADDR_W'(32'h1000)) |-> bus_rdata[23]);

    // R7
    a_r7_mid_bit: assert property (@(posedge clk) disable iff (rst)
        (aligned == ADDR_W'(32'h2000)) |-> bus_rdata[3]);

    // R9
    a_r9_irq_set: assert property (@(posedge clk) disable iff (rst)
        flt_strobe |=> fault_irq);

    // R10
    a_r10_irq_clear: assert property (@(posedge clk) disable iff (rst)
        (touch && !flt_strobe) |=> !fault_irq);

    // R10
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (rst)
        (!touch && !flt_strobe) |=> $stable(fault_irq));
endmodule

bind xlat_csr_bank xlat_csr_bank_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wen    (bus_wen),
    .bus_ren    (bus_ren),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .flt_strobe (flt_strobe),
    .fault_irq  (fault_irq),
    .win_mask   (win_mask)
);

// File: tb/xlat_csr_bank_test.sv
`timescale 1ns/1ps
module xlat_csr_bank_test;
    localparam int         AW  = 14;
    localparam logic [7:0] VER = 8'h5C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wen = 1'b0, bus_ren = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          flt_strobe = 1'b0;
    logic [31:0]   flt_status = '0, flt_addr = '0;
    logic [31:0]   win_mask;
    logic          fault_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    xlat_csr_bank #(.ADDR_W(AW), .SLOTS(4), .VERSION(VER)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_strobe(flt_strobe), .flt_status(flt_status), .flt_addr(flt_addr),
        .win_mask(win_mask), .fault_irq(fault_irq)
    );

    // kind 0: read data, 1: interrupt, 2: window mask
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = (it.kind == 0) ? bus_rdata :
                  (it.kind == 1) ? {31'b0, fault_irq} : win_mask;
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: got %08h expected %08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic drive(input logic [AW-1:0] a, input logic w, input logic r,
                         input logic [31:0] d, input logic s,
                         input logic [31:0] fs, input logic [31:0] fa);
        @(posedge clk); #1;
        bus_addr = a; bus_wen = w; bus_ren = r; bus_wdata = d;
        flt_strobe = s; flt_status = fs; flt_addr = fa;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        drive(a, 1'b1, 1'b0, d, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        drive(a, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0, 32'h0);
        it.kind = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk(input int k, input logic [31:0] e, input string tag);
        item_t it;
        drive('0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic flt(input logic [31:0] fs, input logic [31:0] fa);
        drive('0, 1'b0, 1'b0, 32'h0, 1'b1, fs, fa);
        @(negedge clk);
    endtask

    task automatic flt_wr(input logic [31:0] fs, input logic [31:0] fa,
                          input logic [AW-1:0] a, input logic [31:0] d);
        drive(a, 1'b1, 1'b0, d, 1'b1, fs, fa);
        @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input logic [31:0] low);
        return {VER, 24'h0} | low;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8 reset state
        rd(14'h0000, ctrl_word(32'h0), "R8 ctrl reset");
        rd(14'h2000, 32'h0000_0008, "R8 arb reset");
        rd(14'h1000, 32'h0080_0000, "R8 fstat reset");
        rd(14'h0004, 32'h0, "R8 base reset");
        rd(14'h1014, 32'h0, "R8 slot reset");
        chk(1, 32'h0, "R8 irq reset");
        chk(2, 32'h0, "R8 mask reset");

        // R1 / R2
        wr(14'h0000, 32'hFFFF_FFFF);
        chk(2, 32'h8000_0000, "R2 range 7");
        rd(14'h0000, ctrl_word(32'h0000_001D), "R1 ctrl mask all ones");
        wr(14'h0000, 32'h0000_0000);
        chk(2, 32'hFF00_0000, "R2 range 0");
        wr(14'h0000, 32'h0000_000C);
        chk(2, 32'hF800_0000, "R2 range 3");
        rd(14'h0000, ctrl_word(32'h0000_000C), "R1 ctrl range 3");
        wr(14'h0004, 32'hFFFF_FFFF);
        chk(2, 32'hF800_0000, "R2 mask held on other write");

        // R3
        rd(14'h0004, 32'h07FF_FC00, "R3 base all ones");
        wr(14'h0004, 32'h1234_5678);
        rd(14'h0004, 32'h0234_5400, "R3 base pattern");

        // R4
        wr(14'h0014, 32'hDEAD_BEEF);
        wr(14'h0018, 32'hA5A5_5A5A);
        rd(14'h0014, 32'hDEAD_BEEF, "R4 tlb flush");
        rd(14'h0018, 32'hA5A5_5A5A, "R4 page flush");

        // R5
        wr(14'h1000, 32'hFFFF_FFFF);
        rd(14'h1000, 32'hFF8F_FFFF, "R5 fstat all ones");
        wr(14'h1000, 32'h0000_0000);
        rd(14'h1000, 32'h0080_0000, "R5 fstat zero");
        wr(14'h1004, 32'hCAFE_F00D);
        rd(14'h1004, 32'hCAFE_F00D, "R5 faddr");

        // R6
        for (int i = 0; i < 4; i++) wr(14'(14'h1010 + 4 * i), 32'hFFFF_FFF0 | 32'(i));
        for (int i = 0; i < 4; i++)
            rd(14'(14'h1010 + 4 * i), 32'h0001_0000 | 32'(i), "R6 slot");

        // R7
        wr(14'h2000, 32'hFFFF_FFFF);
        rd(14'h2000, 32'h001F_0008, "R7 arb all ones");
        wr(14'h2000, 32'h0);
        rd(14'h2000, 32'h0000_0008, "R7 arb zero");

        // R11
        wr(14'h0008, 32'hFFFF_FFFF);
        rd(14'h0008, 32'h0, "R11 unmapped 0x0008");
        rd(14'h1008, 32'h0, "R11 unmapped 0x1008");
        rd(14'h3FFC, 32'h0, "R11 unmapped 0x3FFC");
        rd(14'h0006, 32'h0234_5400, "R11 low bits ignored");
        rd(14'h0004, 32'h0234_5400, "R11 base untouched by unmapped write");

        // R9 / R10
        flt(32'h1234_5678, 32'hABCD_0000);
        chk(1, 32'h1, "R9 irq set");
        rd(14'h1000, 32'h1284_5678, "R9 captured status");
        chk(1, 32'h0, "R10 cleared by status read");
        flt(32'h0, 32'h0000_1000);
        wr(14'h0014, 32'h1);
        chk(1, 32'h1, "R10 other write keeps irq");
        rd(14'h0018, 32'hA5A5_5A5A, "R10 other read");
        chk(1, 32'h1, "R10 other read keeps irq");
        rd(14'h1004, 32'h0000_1000, "R9 captured address");
        chk(1, 32'h0, "R10 cleared by address read");
        flt(32'h0, 32'h0000_2000);
        wr(14'h1004, 32'h5);
        chk(1, 32'h0, "R10 cleared by address write");
        flt_wr(32'h0, 32'h1111_0000, 14'h1004, 32'h2222_0000);
        chk(1, 32'h1, "R9 irq set on collision");
        rd(14'h1004, 32'h1111_0000, "R9 capture wins");
        rd(14'h1000, 32'h0080_0000, "R9 status folded");

        chk(1, 32'h0, "R10 final irq");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule